// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

A clocked controller that sits between a simple synchronous request port and an external asynchronous static RAM of 32,768 bytes. The user side raises a request with an address, a direction flag and, for writes, a data byte. The controller latches these and then drives the RAM's active-low chip select, output enable and write enable strobes through a fixed sequence. Each phase of that sequence lasts a whole number of clock cycles, derived from the RAM's nanosecond timings.

The RAM's bidirectional data bus is split into an input, an output and an output-enable at this block's edge, so that the pad tristate buffer sits outside. Reads are registered on the final cycle of the read phase. A one-cycle done pulse follows both reads and writes, and a busy flag stays high from acceptance until the controller is idle again.

Each phase length is ceil(ns / clock period), with a floor of one cycle. The write pulse is the largest of the pulse-width length, the data-setup length plus one, and the write-cycle length minus one. The read phase is the largest of the access-time lengths and the read-cycle length minus one. With the default 10 ns clock, these give a 6-cycle write pulse and a 7-cycle read phase.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip select, output enable and write enable are high (1), the data driver enable is 0, and busy and done are 0.
- R2: A write holds chip select and write enable low, with output enable high, for exactly the write-pulse length (6 cycles by default).
- R3: The data driver enable is 1 only in cycles where write enable is low, was already low in the previous cycle, and output enable is high. It falls on the same clock edge that raises write enable.
- R4: Write data is driven for at least the data-setup length (3 cycles by default) before write enable rises, and it equals the requested byte.
- R5: A read holds chip select and output enable low, with write enable high, for exactly the read-phase length (7 cycles by default). The byte on the data input in the last cycle of that phase is the one captured.
- R6: done is high for exactly one cycle, namely the first cycle after the strobes return high. In that cycle the read data output holds the captured byte.
- R7: busy is 1 from the cycle after a request is accepted until the controller is idle again. Requests raised while busy is 1 are ignored.
- R8: The RAM address changes only while chip select is high. Between two chip-select-low phases there are at least two cycles with every strobe high: one idle gap cycle and one setup cycle.
- R9: Output enable and write enable are never low together. Neither of them is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, accepted when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (15) | Request address |
| req_wdata_i | input | DATA_W (8) | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W (8) | Captured read data |
| mem_addr_o | output | ADDR_W (15) | RAM address |
| mem_cs_no | output | 1 | RAM chip select, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_we_no | output | 1 | RAM write enable, active low |
| mem_dq_i | input | DATA_W (8) | Data from the RAM pad |
| mem_dq_o | output | DATA_W (8) | Data toward the RAM pad |
| mem_dq_oe_o | output | 1 | Pad driver enable |

## Verification
The assertions assume that the RAM releases the bus within the cycles the controller leaves idle. They also assume that the user port holds a request only while the controller is in a state that can accept it or ignore it. The bench's RAM model honours the access time by returning a garbage byte until the read phase has lasted long enough. The stimulus sweeps every address of a small configuration, issues back-to-back requests, and raises requests while busy. It drives all inputs only at falling clock edges, so the strobe sequence is never perturbed mid-cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WRITE,
    ST_READ,
    ST_GAP
  } seq_state_e;

  // cycles for a nanosecond span, at least one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WR_LEN = 6,
  parameter int RD_LEN = 7,
  parameter int CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_q_i,
  input  logic             phase_last_i,
  output logic             accept_o,
  output logic             capture_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cs_no,
  output logic             oe_no,
  output logic             we_no,
  output logic             drive_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_SETUP;
      ST_SETUP: state_d = wr_q_i ? ST_WRITE : ST_READ;
      ST_WRITE: if (phase_last_i) state_d = ST_GAP;
      ST_READ:  if (phase_last_i) state_d = ST_GAP;
      ST_GAP:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign accept_o   = (state_q == ST_IDLE) && req_i;
  assign capture_o  = (state_q == ST_READ) && phase_last_i;
  assign load_o     = (state_q == ST_SETUP);
  assign load_val_o = wr_q_i ? CNT_W'(WR_LEN) : CNT_W'(RD_LEN);
  assign busy_o     = (state_q != ST_IDLE);

  // strobes are flops so the RAM never sees decode glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_no   <= 1'b1;
      oe_no   <= 1'b1;
      we_no   <= 1'b1;
      drive_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_no   <= !((state_d == ST_WRITE) || (state_d == ST_READ));
      we_no   <= !(state_d == ST_WRITE);
      oe_no   <= !(state_d == ST_READ);
      // drive only once WE has been low for a full cycle
      drive_o <= (state_d == ST_WRITE) && (state_q == ST_WRITE);
      done_o  <= (state_d == ST_GAP);
    end
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              wr_q_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q_o  <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      wr_q_o  <= wr_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= dq_i;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_WP_NS  = 55,
  parameter int T_WC_NS  = 70,
  parameter int T_DW_NS  = 30,
  parameter int T_AA_NS  = 70,
  parameter int T_ACS_NS = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_RC_NS  = 70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  localparam int WR_LEN = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS) + 1),
                               ns2cyc(T_WC_NS, CLK_NS) - 1);
  localparam int RD_LEN = imax(imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_ACS_NS, CLK_NS)),
                               imax(ns2cyc(T_OE_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS) - 1));
  localparam int CNT_W  = $clog2(imax(WR_LEN, RD_LEN) + 1);

  logic             accept, capture, load, phase_last, wr_q;
  logic [CNT_W-1:0] load_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (phase_last)
  );

  sram_seq_fsm #(.WR_LEN(WR_LEN), .RD_LEN(RD_LEN), .CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .wr_q_i       (wr_q),
    .phase_last_i (phase_last),
    .accept_o     (accept),
    .capture_o    (capture),
    .load_o       (load),
    .load_val_o   (load_val),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cs_no        (mem_cs_no),
    .oe_no        (mem_oe_no),
    .we_no        (mem_we_no),
    .drive_o      (mem_dq_oe_o)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .wr_i      (req_wr_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .dq_i      (mem_dq_i),
    .wr_q_o    (wr_q),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_dq_o),
    .rdata_o   (rdata_o)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic              mem_dq_oe_o
);

  // R3
  drive_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_no && mem_oe_no && !$past(mem_we_no)));

  // R3
  drive_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> !mem_dq_oe_o);

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  // R9
  strobe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !mem_cs_no);

  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_cs_no && $past(!mem_cs_no) && busy_o));

  // R7
  busy_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_no |-> busy_o);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs_no   (mem_cs_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WR_EXP = mx(mx(cyc(55), cyc(30) + 1), cyc(70) - 1);
  localparam int RD_EXP = mx(mx(cyc(70), cyc(70)), mx(cyc(35), cyc(70) - 1));
  localparam int DS_EXP = cyc(30);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic cs_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] dq_in, dq_out;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .req_wr_i    (req_wr),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .busy_o      (busy),
    .done_o      (done),
    .rdata_o     (rdata),
    .mem_addr_o  (mem_addr),
    .mem_cs_no   (cs_n),
    .mem_oe_no   (oe_n),
    .mem_we_no   (we_n),
    .mem_dq_i    (dq_in),
    .mem_dq_o    (dq_out),
    .mem_dq_oe_o (dq_oe)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // RAM model: data valid only after the access time has elapsed
  logic [DW-1:0] mem [DEPTH];
  int acc_cnt = 0;
  assign dq_in = (acc_cnt >= RD_EXP) ? mem[mem_addr] : 8'hA5;

  logic cs_prev = 1'b1, we_prev = 1'b1, was_wr = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  int run_len = 0, hi_run = 2, drv_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && !oe_n && we_n) acc_cnt <= acc_cnt + 1;
      else acc_cnt <= 0;
      if (!cs_n && !we_n && dq_oe) mem[mem_addr] <= dq_out;
      // R9
      chk(!(!oe_n && !we_n) && (cs_n ? (oe_n && we_n) : 1'b1), "R9", "strobes", {oe_n, we_n}, 3);
      if (dq_oe)
        chk(!we_n && oe_n && !we_prev, "R3", "driver window", {we_n, oe_n, we_prev}, 2);
      if (!cs_n && !cs_prev)
        chk(mem_addr == addr_prev, "R8", "addr while selected", mem_addr, addr_prev);
      if (!cs_n && cs_prev) begin
        chk(hi_run >= 2, "R8", "idle strobe cycles", hi_run, 2);
        run_len <= 1;
        drv_cnt <= dq_oe ? 1 : 0;
        was_wr  <= !we_n;
      end else if (!cs_n) begin
        run_len <= run_len + 1;
        if (dq_oe) drv_cnt <= drv_cnt + 1;
      end
      if (cs_n && !cs_prev) begin
        if (was_wr) begin
          chk(run_len == WR_EXP, "R2", "write pulse len", run_len, WR_EXP);
          chk(drv_cnt >= DS_EXP && drv_cnt == WR_EXP - 1, "R4", "drive cycles", drv_cnt, WR_EXP - 1);
          chk(!dq_oe, "R3", "release with WE", dq_oe, 0);
        end else begin
          chk(run_len == RD_EXP, "R5", "read phase len", run_len, RD_EXP);
        end
      end
      hi_run    <= cs_n ? hi_run + 1 : 0;
      cs_prev   <= cs_n;
      we_prev   <= we_n;
      addr_prev <= mem_addr;
    end
  end

  // one transaction, entered at a falling edge with the controller idle
  task automatic xfer(input bit wr, input int a, input int d, input int exp, input bit poke);
    req = 1'b1; req_wr = wr; req_addr = AW'(a); req_wdata = DW'(d);
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    chk(busy && cs_n && oe_n && we_n, "R7", "setup busy/strobes", {busy, cs_n, oe_n, we_n}, 15);
    chk(mem_addr == AW'(a), "R8", "addr in setup", mem_addr, a);
    for (int k = 1; k <= (wr ? WR_EXP : RD_EXP); k++) begin
      @(negedge clk);
      if (poke && k == 2) begin
        req = 1'b1; req_wr = 1'b1; req_addr = AW'(a ^ 9); req_wdata = 8'h3C;
      end
      if (wr) begin
        chk(!cs_n && !we_n && oe_n, "R2", "write strobes", {cs_n, we_n, oe_n}, 1);
        chk(dq_oe == (k >= 2), "R3", "driver enable", dq_oe, k >= 2);
        if (k >= 2) chk(dq_out == DW'(d), "R4", "write data", dq_out, d);
      end else begin
        chk(!cs_n && !oe_n && we_n, "R5", "read strobes", {cs_n, oe_n, we_n}, 1);
      end
      chk(!done && busy, "R6", "no early done", {done, busy}, 1);
    end
    @(negedge clk);
    req = 1'b0;
    chk(cs_n && oe_n && we_n && !dq_oe, "R8", "gap strobes", {cs_n, oe_n, we_n, dq_oe}, 14);
    chk(done && busy, "R6", "done pulse", {done, busy}, 3);
    if (!wr) chk(rdata == DW'(exp), "R5", "read data", rdata, exp);
    @(negedge clk);
    chk(!busy && !done, "R7", "back to idle", {busy, done}, 0);
    if (!wr) chk(rdata == DW'(exp), "R6", "rdata held", rdata, exp);
  endtask

  function automatic int pat1(input int a); return (a * 29 + 7) & 8'hFF; endfunction
  function automatic int pat2(input int a); return (~pat1(a) ^ (a << 2)) & 8'hFF; endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cs_n && oe_n && we_n && !dq_oe && !busy && !done, "R1", "reset outputs",
        {cs_n, oe_n, we_n, dq_oe, busy, done}, 8'h38);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && oe_n && we_n && !dq_oe && !busy && !done, "R1", "after reset",
        {cs_n, oe_n, we_n, dq_oe, busy, done}, 8'h38);

    for (int a = 0; a < DEPTH; a++) xfer(1'b1, a, pat1(a), 0, 1'b0);
    for (int a = 0; a < DEPTH; a++) xfer(1'b0, a, 0, pat1(a), 1'b0);
    for (int a = DEPTH - 1; a >= 0; a--) xfer(1'b1, a, pat2(a), 0, 1'b0);
    for (int a = DEPTH - 1; a >= 0; a--) xfer(1'b0, a, 0, pat2(a), 1'b0);

    // boundary bytes at both address ends
    xfer(1'b1, 0, 8'h00, 0, 1'b0);
    xfer(1'b1, DEPTH - 1, 8'hFF, 0, 1'b0);
    xfer(1'b0, DEPTH - 1, 0, 8'hFF, 1'b0);
    xfer(1'b0, 0, 0, 8'h00, 1'b0);

    // R7: a write raised while busy must not happen
    xfer(1'b0, 5, 0, pat2(5), 1'b1);
    @(negedge clk);
    chk(!busy, "R7", "ignored request left no work", busy, 0);
    xfer(1'b0, 5 ^ 9, 0, pat2(5 ^ 9), 1'b0);
    xfer(1'b1, 5, 8'h3C, 0, 1'b1);
    xfer(1'b0, 5 ^ 9, 0, pat2(5 ^ 9), 1'b0);
    xfer(1'b0, 5, 0, 8'h3C, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule